// File: doc/BRIEF.md
# Configurable SAD/MSE Processing Cell

This block is one cell of a two-dimensional systolic array that computes window error metrics between a block of current-frame pixels and a block of reference-frame pixels. The cell holds one current-frame pixel. Each cycle it compares that pixel with a streamed reference pixel, producing either the absolute difference or the squared difference. It adds the result to the column partial sum arriving from the cell above and registers the total for the cell below.

Every cell carries the full set of "last row of a block" hardware. Run-time block height and width, together with the cell's own row and column index, decide three things: whether the column input is zeroed (top row of a block), whether the row input is zeroed (left column of a block), and how many cycles the column total waits before the row adder folds it into the row-accumulated block result. One physical array can therefore be divided into many smaller blocks without rewiring. A valid flag travels with each partial sum, so idle cycles produce flagged-invalid results and the pipeline never stalls.

Top module: `sadmse_cell`

## Requirements
- R1: While `rst_n` is low, `col_out` and `row_out` are zero and `col_out_vld` and `row_out_vld` are low.
- R2: With `metric_sq` = 0, the per-pixel term is |stored pixel − `ref_pix`|, both unsigned 8-bit.
- R3: With `metric_sq` = 1, the per-pixel term is (stored pixel − `ref_pix`)², at most 65025.
- R4: Let the effective height be `blk_h`, or 1 when `blk_h` is 0, and let r = `row_idx` mod that height. The column term added is zero when r = 0 and `col_in` otherwise. `col_out` equals term + per-pixel value one clock edge after the inputs are sampled, wrapping at 20 bits.
- R5: `col_out_vld` is `ref_vld` AND (r = 0 OR `col_in_vld`), registered with `col_out`.
- R6: Let c = `col_idx` mod the effective width (`blk_w`, or 1 when 0). `row_out` is the `col_out` value from c cycles earlier (c = 0 means the current `col_out`), plus zero when c = 0 or `row_in` otherwise, registered at the next edge. Over the sum, inputs sampled at edge k reach `row_out` after edge k+1+c. The sum wraps at 24 bits.
- R7: `row_out_vld` can be high only when the cell was a last-row cell (r = effective height − 1) at the edge that produced it; interior cells keep it low.
- R8: The stored current pixel takes `cur_pix_in` at an edge where `cur_we` is 1 and keeps its value otherwise.
- R9: A block size of 0 behaves as size 1: every row is both top and last row, and every column is the leftmost, so `col_in` and `row_in` have no effect.
- R10: `row_out_vld` requires the delayed column valid and, when c ≠ 0, `row_in_vld` at the producing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| metric_sq | input | 1 | 0 = absolute difference, 1 = squared difference |
| blk_h | input | 5 | Block height in rows (0 treated as 1) |
| blk_w | input | 5 | Block width in columns (0 treated as 1) |
| row_idx | input | 5 | Row index of this cell in the array |
| col_idx | input | 5 | Column index of this cell in the array |
| cur_we | input | 1 | Load enable for the stored current pixel |
| cur_pix_in | input | 8 | Current-frame pixel to store |
| ref_pix | input | 8 | Streamed reference pixel |
| ref_vld | input | 1 | Reference pixel valid |
| col_in | input | 20 | Column partial sum from the cell above |
| col_in_vld | input | 1 | Valid for `col_in` |
| row_in | input | 24 | Row partial sum from the left neighbour |
| row_in_vld | input | 1 | Valid for `row_in` |
| col_out | output | 20 | Registered column partial sum |
| col_out_vld | output | 1 | Valid for `col_out` |
| row_out | output | 24 | Registered row-accumulated block result |
| row_out_vld | output | 1 | Valid for `row_out` |

## Verification
Directed patterns come first. Extreme pixel pairs (255 against 0, a stored value against a larger reference) separate the two metrics and the sign handling. A top-row against a lower-row placement shows whether `col_in` is admitted. A ramp of reference values on a column-2 last-row cell shows the exact tap the delay line picks, since each cycle carries a different sum. Zero block sizes show that neighbour inputs are shut out. Random traffic then varies pixel values, valid gaps, metric and block placement every few dozen cycles, which exercises valid gating and the delay selection for all positions against a cycle model in the bench.

// File: rtl/sadmse_pkg.sv
package sadmse_pkg;
  typedef enum logic {
    MET_ABS = 1'b0,
    MET_SQR = 1'b1
  } metric_e;

  localparam int unsigned PIX_W_DEF   = 8;
  localparam int unsigned COL_W_DEF   = 20;
  localparam int unsigned ROW_W_DEF   = 24;
  localparam int unsigned MAX_DIM_DEF = 16;
endpackage

// File: rtl/sadmse_pixel_metric.sv
module sadmse_pixel_metric
  import sadmse_pkg::*;
#(
  parameter int unsigned PIX_W = PIX_W_DEF,
  parameter int unsigned OUT_W = COL_W_DEF
) (
  input  logic [PIX_W-1:0] cur_pix,
  input  logic [PIX_W-1:0] ref_pix,
  input  metric_e          metric,
  output logic [OUT_W-1:0] term
);
  localparam int unsigned SQ_W = 2 * PIX_W;

  logic [PIX_W:0]   diff;
  logic [PIX_W:0]   diff_neg;
  logic [PIX_W-1:0] mag;
  logic [SQ_W-1:0]  sq;

  always_comb begin
    diff     = {1'b0, cur_pix} - {1'b0, ref_pix};
    diff_neg = {1'b0, ref_pix} - {1'b0, cur_pix};
    mag      = diff[PIX_W] ? diff_neg[PIX_W-1:0] : diff[PIX_W-1:0];
    sq       = SQ_W'(mag) * SQ_W'(mag);
    if (metric == MET_SQR) term = {{(OUT_W-SQ_W){1'b0}}, sq};
    else                   term = {{(OUT_W-PIX_W){1'b0}}, mag};
  end
endmodule

// File: rtl/sadmse_placement.sv
module sadmse_placement #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] blk_h,
  input  logic [IDX_W-1:0] blk_w,
  input  logic [IDX_W-1:0] row_idx,
  input  logic [IDX_W-1:0] col_idx,
  output logic             first_row,
  output logic             last_row,
  output logic [IDX_W-1:0] col_pos
);
  localparam int unsigned ITER = 2 ** IDX_W;

  logic [IDX_W-1:0] h_eff;
  logic [IDX_W-1:0] w_eff;
  logic [IDX_W-1:0] r_pos;
  logic [IDX_W-1:0] c_pos;

  // Modulo by repeated subtraction; the index never exceeds ITER-1.
  always_comb begin
    h_eff = (blk_h == '0) ? IDX_W'(1) : blk_h;
    w_eff = (blk_w == '0) ? IDX_W'(1) : blk_w;
    r_pos = row_idx;
    c_pos = col_idx;
    for (int k = 0; k < ITER; k++) begin
      if (r_pos >= h_eff) r_pos = r_pos - h_eff;
      if (c_pos >= w_eff) c_pos = c_pos - w_eff;
    end
    first_row = (r_pos == '0);
    last_row  = (r_pos == h_eff - IDX_W'(1));
    col_pos   = c_pos;
  end
endmodule

// File: rtl/sadmse_tap_delay.sv
module sadmse_tap_delay #(
  parameter int unsigned W     = 20,
  parameter int unsigned DEPTH = 15,
  parameter int unsigned SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     d_in,
  input  logic             v_in,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     d_out,
  output logic             v_out
);
  logic [W-1:0]     st_d [DEPTH];
  logic             st_v [DEPTH];
  logic [SEL_W-1:0] sel_c;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] nxt_d;
    logic         nxt_v;
    if (g == 0) begin : g_head
      always_comb begin
        nxt_d = d_in;
        nxt_v = v_in;
      end
    end else begin : g_body
      always_comb begin
        nxt_d = st_d[g-1];
        nxt_v = st_v[g-1];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_d[g] <= '0;
        st_v[g] <= 1'b0;
      end else begin
        st_d[g] <= nxt_d;
        st_v[g] <= nxt_v;
      end
    end
  end

  always_comb begin
    sel_c = (sel > SEL_W'(DEPTH)) ? SEL_W'(DEPTH) : sel;
    d_out = d_in;
    v_out = v_in;
    for (int k = 1; k <= DEPTH; k++) begin
      if (sel_c == SEL_W'(k)) begin
        d_out = st_d[k-1];
        v_out = st_v[k-1];
      end
    end
  end
endmodule

// File: rtl/sadmse_cell.sv
module sadmse_cell
  import sadmse_pkg::*;
#(
  parameter int unsigned PIX_W   = PIX_W_DEF,
  parameter int unsigned COL_W   = COL_W_DEF,
  parameter int unsigned ROW_W   = ROW_W_DEF,
  parameter int unsigned MAX_DIM = MAX_DIM_DEF,
  localparam int unsigned IDX_W  = $clog2(MAX_DIM + 1),
  localparam int unsigned DEPTH  = MAX_DIM - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             metric_sq,
  input  logic [IDX_W-1:0] blk_h,
  input  logic [IDX_W-1:0] blk_w,
  input  logic [IDX_W-1:0] row_idx,
  input  logic [IDX_W-1:0] col_idx,
  input  logic             cur_we,
  input  logic [PIX_W-1:0] cur_pix_in,
  input  logic [PIX_W-1:0] ref_pix,
  input  logic             ref_vld,
  input  logic [COL_W-1:0] col_in,
  input  logic             col_in_vld,
  input  logic [ROW_W-1:0] row_in,
  input  logic             row_in_vld,
  output logic [COL_W-1:0] col_out,
  output logic             col_out_vld,
  output logic [ROW_W-1:0] row_out,
  output logic             row_out_vld
);
  logic [PIX_W-1:0] cur_q, cur_nxt;
  logic [COL_W-1:0] term;
  logic [COL_W-1:0] col_add, col_nxt;
  logic             col_vld_nxt;
  logic [ROW_W-1:0] row_add, row_nxt;
  logic             row_vld_nxt;
  logic             first_row, last_row;
  logic [IDX_W-1:0] col_pos;
  logic [COL_W-1:0] tap_d;
  logic             tap_v;
  metric_e          metric;

  assign metric = metric_e'(metric_sq);

  sadmse_pixel_metric #(.PIX_W(PIX_W), .OUT_W(COL_W)) u_metric (
    .cur_pix (cur_q),
    .ref_pix (ref_pix),
    .metric  (metric),
    .term    (term)
  );

  sadmse_placement #(.IDX_W(IDX_W)) u_place (
    .blk_h     (blk_h),
    .blk_w     (blk_w),
    .row_idx   (row_idx),
    .col_idx   (col_idx),
    .first_row (first_row),
    .last_row  (last_row),
    .col_pos   (col_pos)
  );

  sadmse_tap_delay #(.W(COL_W), .DEPTH(DEPTH), .SEL_W(IDX_W)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (col_out),
    .v_in  (col_out_vld),
    .sel   (col_pos),
    .d_out (tap_d),
    .v_out (tap_v)
  );

  always_comb begin
    cur_nxt     = cur_we ? cur_pix_in : cur_q;
    col_add     = first_row ? '0 : col_in;
    col_nxt     = term + col_add;
    col_vld_nxt = ref_vld & (first_row | col_in_vld);
    row_add     = (col_pos == '0) ? '0 : row_in;
    row_nxt     = {{(ROW_W-COL_W){1'b0}}, tap_d} + row_add;
    row_vld_nxt = last_row & tap_v & ((col_pos == '0) | row_in_vld);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q       <= '0;
      col_out     <= '0;
      col_out_vld <= 1'b0;
      row_out     <= '0;
      row_out_vld <= 1'b0;
    end else begin
      cur_q       <= cur_nxt;
      col_out     <= col_nxt;
      col_out_vld <= col_vld_nxt;
      row_out     <= row_nxt;
      row_out_vld <= row_vld_nxt;
    end
  end
endmodule

// File: rtl/sadmse_cell_chk.sv
module sadmse_cell_chk #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned COL_W = 20,
  parameter int unsigned IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             metric_sq,
  input logic [IDX_W-1:0] blk_h,
  input logic [IDX_W-1:0] blk_w,
  input logic [IDX_W-1:0] row_idx,
  input logic [IDX_W-1:0] col_idx,
  input logic             cur_we,
  input logic [PIX_W-1:0] cur_q,
  input logic [PIX_W-1:0] ref_pix,
  input logic             ref_vld,
  input logic             row_in_vld,
  input logic [COL_W-1:0] col_out,
  input logic             col_out_vld,
  input logic             row_out_vld
);
  logic [IDX_W-1:0] hh, ww;
  logic             is_top, is_last, not_left;
  logic [COL_W-1:0] abs_ref;

  always_comb begin
    hh       = (blk_h == '0) ? IDX_W'(1) : blk_h;
    ww       = (blk_w == '0) ? IDX_W'(1) : blk_w;
    is_top   = (row_idx % hh) == '0;
    is_last  = (row_idx % hh) == (hh - IDX_W'(1));
    not_left = (col_idx % ww) != '0;
    abs_ref  = (cur_q >= ref_pix) ? COL_W'(cur_q - ref_pix) : COL_W'(ref_pix - cur_q);
  end

  // R5
  col_vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_out_vld |-> $past(ref_vld));

  // R7
  row_vld_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_out_vld |-> $past(is_last));

  // R8
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_we |=> $stable(cur_q));

  // R2
  abs_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_vld && !metric_sq && is_top) |=> (col_out == $past(abs_ref)));

  // R10
  row_chain_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_out_vld && $past(not_left)) |-> $past(row_in_vld));
endmodule

bind sadmse_cell sadmse_cell_chk #(.PIX_W(PIX_W), .COL_W(COL_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .metric_sq   (metric_sq),
  .blk_h       (blk_h),
  .blk_w       (blk_w),
  .row_idx     (row_idx),
  .col_idx     (col_idx),
  .cur_we      (cur_we),
  .cur_q       (cur_q),
  .ref_pix     (ref_pix),
  .ref_vld     (ref_vld),
  .row_in_vld  (row_in_vld),
  .col_out     (col_out),
  .col_out_vld (col_out_vld),
  .row_out_vld (row_out_vld)
);

// File: tb/tb_sadmse_cell.sv
`timescale 1ns/1ps
module tb_sadmse_cell;
  localparam int COL_W = 20;
  localparam int ROW_W = 24;
  localparam int HD    = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic metric_sq = 1'b0;
  logic [4:0] blk_h = 5'd1, blk_w = 5'd1, row_idx = '0, col_idx = '0;
  logic cur_we = 1'b0;
  logic [7:0] cur_pix_in = '0, ref_pix = '0;
  logic ref_vld = 1'b0;
  logic [COL_W-1:0] col_in = '0;
  logic col_in_vld = 1'b0;
  logic [ROW_W-1:0] row_in = '0;
  logic row_in_vld = 1'b0;
  logic [COL_W-1:0] col_out;
  logic col_out_vld;
  logic [ROW_W-1:0] row_out;
  logic row_out_vld;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sadmse_cell dut (
    .clk(clk), .rst_n(rst_n), .metric_sq(metric_sq), .blk_h(blk_h), .blk_w(blk_w),
    .row_idx(row_idx), .col_idx(col_idx), .cur_we(cur_we), .cur_pix_in(cur_pix_in),
    .ref_pix(ref_pix), .ref_vld(ref_vld), .col_in(col_in), .col_in_vld(col_in_vld),
    .row_in(row_in), .row_in_vld(row_in_vld), .col_out(col_out), .col_out_vld(col_out_vld),
    .row_out(row_out), .row_out_vld(row_out_vld)
  );

  function automatic logic [COL_W-1:0] f_term(logic [7:0] a, logic [7:0] b, logic sq);
    int d;
    d = int'(a) - int'(b);
    if (d < 0) d = -d;
    return sq ? COL_W'(d * d) : COL_W'(d);
  endfunction

  function automatic int f_eff(logic [4:0] s);
    return (s == 0) ? 1 : int'(s);
  endfunction

  // Cycle model built from the requirements
  logic [COL_W-1:0] m_col;
  logic             m_colv;
  logic [ROW_W-1:0] m_row;
  logic             m_rowv;
  logic [7:0]       m_cur;
  logic [COL_W-1:0] m_hd [HD];
  logic             m_hv [HD];
  string            m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_col = '0; m_colv = 0; m_row = '0; m_rowv = 0; m_cur = '0; m_tag = "R2";
      for (int k = 0; k < HD; k++) begin m_hd[k] = '0; m_hv[k] = 0; end
    end else begin
      int h, w, r, c;
      logic top, last;
      logic [COL_W-1:0] tapd, ncol;
      logic tapv, ncolv;
      h = f_eff(blk_h); w = f_eff(blk_w);
      r = int'(row_idx) % h; c = int'(col_idx) % w;
      if (c > HD) c = HD;
      top = (r == 0); last = (r == h - 1);
      ncol  = f_term(m_cur, ref_pix, metric_sq) + (top ? '0 : col_in);
      ncolv = ref_vld && (top || col_in_vld);
      tapd = (c == 0) ? m_col : m_hd[c-1];
      tapv = (c == 0) ? m_colv : m_hv[c-1];
      m_row  = ROW_W'(tapd) + ((c == 0) ? '0 : row_in);
      m_rowv = last && tapv && (c == 0 || row_in_vld);
      for (int k = HD - 1; k > 0; k--) begin m_hd[k] = m_hd[k-1]; m_hv[k] = m_hv[k-1]; end
      m_hd[0] = m_col; m_hv[0] = m_colv;
      m_col = ncol; m_colv = ncolv;
      m_tag = metric_sq ? "R3" : "R2";
      if (cur_we) m_cur = cur_pix_in;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      chk({m_tag, "/R4 col_out"}, 32'(col_out), 32'(m_col));
      chk("R5 col_out_vld", 32'(col_out_vld), 32'(m_colv));
      chk("R6 row_out", 32'(row_out), 32'(m_row));
      chk("R7/R10 row_out_vld", 32'(row_out_vld), 32'(m_rowv));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5AD3));
    ref_vld = 1; ref_pix = 8'd77; col_in = 20'd55; col_in_vld = 1;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 col_out", 32'(col_out), 0);
    chk("R1 col_out_vld", 32'(col_out_vld), 0);
    chk("R1 row_out", 32'(row_out), 0);
    chk("R1 row_out_vld", 32'(row_out_vld), 0);
    rst_n = 1;
    ref_vld = 0;
    // R8: load 200, then offer 5 without enable
    blk_h = 4; blk_w = 4; row_idx = 0; col_idx = 0;
    cur_we = 1; cur_pix_in = 200; cyc();
    cur_we = 0; cur_pix_in = 5; ref_pix = 100; ref_vld = 1; metric_sq = 0; cyc();
    chk("R8 held pixel SAD", 32'(col_out), 100);
    // R2 larger reference than stored
    ref_pix = 250; cyc();
    chk("R2 abs diff", 32'(col_out), 50);
    // R3 extreme square
    cur_we = 1; cur_pix_in = 255; cyc();
    cur_we = 0; metric_sq = 1; ref_pix = 0; cyc();
    chk("R3 square 255", 32'(col_out), 65025);
    // R4 lower row admits col_in
    metric_sq = 0; ref_pix = 250; row_idx = 1; col_in = 20'd1000; col_in_vld = 1; cyc();
    chk("R4 col_in added", 32'(col_out), 1005);
    // R5 invalid neighbour gates valid
    col_in_vld = 0; cyc();
    chk("R5 col_in_vld low", 32'(col_out_vld), 0);
    // R9 zero sizes shut out neighbours
    blk_h = 0; blk_w = 0; row_idx = 5; col_idx = 3; col_in = 20'd777; col_in_vld = 0;
    row_in = 24'd9999; row_in_vld = 0; cyc();
    chk("R9 col_in ignored", 32'(col_out), 5);
    chk("R9 col valid", 32'(col_out_vld), 1);
    cyc();
    chk("R9 row_in ignored", 32'(row_out), 5);
    chk("R9 row valid", 32'(row_out_vld), 1);
    // R6 ramp on a column-2 last-row cell
    cur_we = 1; cur_pix_in = 0; cyc(); cur_we = 0;
    blk_h = 1; blk_w = 4; row_idx = 0; col_idx = 2; row_in = 24'd1000; row_in_vld = 1;
    ref_pix = 10; cyc();
    ref_pix = 20; cyc();
    ref_pix = 30; cyc();
    ref_pix = 40; cyc();
    chk("R6 delay 2 tap", 32'(row_out), 1010);
    cyc();
    chk("R6 delay 2 next", 32'(row_out), 1020);
    // R10 left neighbour invalid
    row_in_vld = 0; cyc();
    chk("R10 row_in_vld low", 32'(row_out_vld), 0);
    // R7 interior cell
    blk_h = 4; row_idx = 1; row_in_vld = 1; col_in_vld = 1;
    repeat (3) cyc();
    chk("R7 interior", 32'(row_out_vld), 0);
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      if (i % 48 == 0) begin
        blk_h = 5'($urandom_range(0, 16)); blk_w = 5'($urandom_range(0, 16));
        row_idx = 5'($urandom_range(0, 15)); col_idx = 5'($urandom_range(0, 15));
        metric_sq = 1'($urandom);
      end
      cur_we = ($urandom_range(0, 15) == 0);
      cur_pix_in = 8'($urandom);
      ref_pix = 8'($urandom);
      ref_vld = ($urandom_range(0, 3) != 0);
      col_in = COL_W'($urandom);
      col_in_vld = ($urandom_range(0, 7) != 0);
      row_in = ROW_W'($urandom);
      row_in_vld = ($urandom_range(0, 7) != 0);
      cyc();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule